// File: doc/BRIEF.md
# Keyed Clock-Control Register Bank

This block is the software-facing register file of a clock manager. A host reaches it over a 32-bit memory-mapped bus with a valid/ready request side and a one-cycle registered response. Every register write has to carry a fixed key in the top byte of its data. A write without the key is dropped. An accepted write is stored with that byte forced to zero. The stored words drive the downstream PLL, PLL-channel and clock-divider logic through a flat configuration bus.

Each accepted write also raises a one-cycle update strobe for the logic that owns the register. The downstream logic then re-evaluates its configuration.
- A PLL control word is shared by the PLL and its channels, so a write to it strobes the PLL and every one of its channels.
- A write to a channel word strobes only that channel.
- A write to either word of a divider pair (control or divide value) strobes only that divider.

Word 0 is not stored. It is a read-only lock status word, assembled at read time from live per-PLL power-down and analog-reset inputs.

Top module: `clkmgr_regbank`

## Requirements
- R1: After reset every stored register reads zero, no update strobe is active, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: A write is accepted only when data bits 31:24 equal 0x5A. Any other key leaves every register unchanged, raises no strobe and returns `rsp_err_o` = 1.
- R3: An accepted write stores the data with bits 31:24 cleared. A later read of that address returns the stored value with `rsp_err_o` = 0.
- R4: An access with byte address bits 1:0 not equal to 0 changes nothing, raises no strobe, returns read data 0 and sets `rsp_err_o`.
- R5: A read of byte address 0x00 returns, in bit p, 1 exactly when `pll_pwrdn_i[p]` and `pll_anarst_i[p]` are both 0. All higher bits are 0. A write to 0x00 changes nothing and sets `rsp_err_o`.
- R6: A write to the control word of PLL p (word 1+p) pulses `pll_upd_o[p]` and `chan_upd_o[p*CHAN_PER_PLL +: CHAN_PER_PLL]` for exactly the response cycle, and nothing else.
- R7: A write to channel c (word 1+NUM_PLL+c, channels numbered PLL-major) pulses only `chan_upd_o[c]`.
- R8: A write to divider k's control word (word 1+NUM_PLL+NUM_CHAN+2k) or its divide-value word (the next word) pulses only `div_upd_o[k]`.
- R9: Reads of words past the last mapped word return 0 with no error. Writes there change nothing and set `rsp_err_o`.
- R10: A request is taken when `req_valid_i` and `req_ready_o` are both high. The response is shown on the next cycle, and `req_ready_o` stays low while it is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Bank can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data, key in bits 31:24 |
| rsp_valid_o | output | 1 | Response valid (one cycle) |
| rsp_err_o | output | 1 | Access rejected |
| rsp_rdata_o | output | 32 | Read data |
| pll_pwrdn_i | input | NUM_PLL | Live power-down state per PLL |
| pll_anarst_i | input | NUM_PLL | Live analog-reset state per PLL |
| ctrl_regs_o | output | NREG*32 | Stored words, word 1 in the lowest 32 bits |
| pll_upd_o | output | NUM_PLL | PLL re-evaluate strobes |
| chan_upd_o | output | NUM_PLL*CHAN_PER_PLL | Channel re-evaluate strobes |
| div_upd_o | output | NUM_DIV | Divider re-evaluate strobes |

## Verification
The bench uses the default parameters: four PLLs with two channels each, four dividers and an 8-bit address. This makes the whole 64-word address space small enough to sweep, covering mapped, read-only and unmapped words alike. It also makes all 256 combinations of the power-down and analog-reset inputs reachable for the lock word. Every mapped word gets two write patterns, six wrong keys and all three misaligned offsets. The strobe vector expected for each word is derived from the word number.

// File: rtl/clkmgr_pkg.sv
package clkmgr_pkg;

    // Key byte carried in write data bits 31:24
    localparam logic [7:0]  WR_KEY   = 8'h5A;
    localparam logic [31:0] KEY_MASK = 32'hFF00_0000;

    typedef enum logic [2:0] {
        RGN_LOCK,
        RGN_PLL,
        RGN_CHAN,
        RGN_DIV,
        RGN_NONE
    } region_e;

endpackage

// File: rtl/clkmgr_addr_dec.sv
module clkmgr_addr_dec
    import clkmgr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_PLL  = 4,
    parameter int NUM_CHAN = 8,
    parameter int NUM_DIV  = 4,
    parameter int IDX_W    = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              aligned_o,
    output region_e           region_o,
    output logic [IDX_W-1:0]  slot_o,
    output logic [IDX_W-1:0]  unit_o
);

    localparam logic [31:0] PLL_BASE = 32'd1;
    localparam logic [31:0] CH_BASE  = 32'(1 + NUM_PLL);
    localparam logic [31:0] DV_BASE  = 32'(1 + NUM_PLL + NUM_CHAN);
    localparam logic [31:0] END_W    = 32'(1 + NUM_PLL + NUM_CHAN + 2 * NUM_DIV);

    logic [31:0] word;

    assign word      = 32'(addr_i[ADDR_W-1:2]);
    assign aligned_o = (addr_i[1:0] == 2'b00);
    assign slot_o    = IDX_W'(word - PLL_BASE);

    always_comb begin
        region_o = RGN_NONE;
        unit_o   = '0;
        if (word == 32'd0) begin
            region_o = RGN_LOCK;
        end else if (word < CH_BASE) begin
            region_o = RGN_PLL;
            unit_o   = IDX_W'(word - PLL_BASE);
        end else if (word < DV_BASE) begin
            region_o = RGN_CHAN;
            unit_o   = IDX_W'(word - CH_BASE);
        end else if (word < END_W) begin
            region_o = RGN_DIV;
            unit_o   = IDX_W'((word - DV_BASE) >> 1);
        end
    end

endmodule

// File: rtl/clkmgr_lock_map.sv
module clkmgr_lock_map #(
    parameter int NUM_PLL = 4
) (
    input  logic [NUM_PLL-1:0] pwrdn_i,
    input  logic [NUM_PLL-1:0] anarst_i,
    output logic [31:0]        lock_o
);

    for (genvar p = 0; p < 32; p++) begin : g_bit
        if (p < NUM_PLL) begin : g_pll
            assign lock_o[p] = ~pwrdn_i[p] & ~anarst_i[p];
        end else begin : g_pad
            assign lock_o[p] = 1'b0;
        end
    end

endmodule

// File: rtl/clkmgr_strobe_map.sv
module clkmgr_strobe_map
    import clkmgr_pkg::*;
#(
    parameter int NUM_PLL      = 4,
    parameter int CHAN_PER_PLL = 2,
    parameter int NUM_DIV      = 4,
    parameter int IDX_W        = 5,
    localparam int NUM_CHAN    = NUM_PLL * CHAN_PER_PLL
) (
    input  logic                fire_i,
    input  region_e             region_i,
    input  logic [IDX_W-1:0]    unit_i,
    output logic [NUM_PLL-1:0]  pll_o,
    output logic [NUM_CHAN-1:0] chan_o,
    output logic [NUM_DIV-1:0]  div_o
);

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        assign pll_o[p] = fire_i && (region_i == RGN_PLL) && (unit_i == IDX_W'(p));
    end

    // A PLL control write also reaches every channel owned by that PLL
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        localparam int OWNER = c / CHAN_PER_PLL;
        assign chan_o[c] = fire_i &&
            (((region_i == RGN_CHAN) && (unit_i == IDX_W'(c))) ||
             ((region_i == RGN_PLL)  && (unit_i == IDX_W'(OWNER))));
    end

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
        assign div_o[k] = fire_i && (region_i == RGN_DIV) && (unit_i == IDX_W'(k));
    end

endmodule

// File: rtl/clkmgr_regbank.sv
module clkmgr_regbank
    import clkmgr_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int NUM_PLL      = 4,
    parameter int CHAN_PER_PLL = 2,
    parameter int NUM_DIV      = 4,
    localparam int NUM_CHAN    = NUM_PLL * CHAN_PER_PLL,
    localparam int NREG        = NUM_PLL + NUM_CHAN + 2 * NUM_DIV
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [31:0]          req_wdata_i,
    output logic                 rsp_valid_o,
    output logic                 rsp_err_o,
    output logic [31:0]          rsp_rdata_o,
    input  logic [NUM_PLL-1:0]   pll_pwrdn_i,
    input  logic [NUM_PLL-1:0]   pll_anarst_i,
    output logic [NREG*32-1:0]   ctrl_regs_o,
    output logic [NUM_PLL-1:0]   pll_upd_o,
    output logic [NUM_CHAN-1:0]  chan_upd_o,
    output logic [NUM_DIV-1:0]   div_upd_o
);

    localparam int IDX_W = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][31:0] regs;
        logic                  rsp_valid;
        logic                  rsp_err;
        logic [31:0]           rdata;
        logic [NUM_PLL-1:0]    pll_stb;
        logic [NUM_CHAN-1:0]   chan_stb;
        logic [NUM_DIV-1:0]    div_stb;
    } state_t;

    state_t st_d, st_q;

    logic                aligned;
    region_e             region;
    logic [IDX_W-1:0]    slot;
    logic [IDX_W-1:0]    unit;
    logic [31:0]         lock_word;
    logic                accept;
    logic                key_ok;
    logic                writable;
    logic                fire;
    logic [NUM_PLL-1:0]  pll_fire;
    logic [NUM_CHAN-1:0] chan_fire;
    logic [NUM_DIV-1:0]  div_fire;

    clkmgr_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_PLL  (NUM_PLL),
        .NUM_CHAN (NUM_CHAN),
        .NUM_DIV  (NUM_DIV),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr_i    (req_addr_i),
        .aligned_o (aligned),
        .region_o  (region),
        .slot_o    (slot),
        .unit_o    (unit)
    );

    clkmgr_lock_map #(
        .NUM_PLL (NUM_PLL)
    ) u_lock (
        .pwrdn_i  (pll_pwrdn_i),
        .anarst_i (pll_anarst_i),
        .lock_o   (lock_word)
    );

    assign accept   = req_valid_i && req_ready_o;
    assign key_ok   = (req_wdata_i[31:24] == WR_KEY);
    assign writable = (region == RGN_PLL) || (region == RGN_CHAN) || (region == RGN_DIV);
    assign fire     = accept && aligned && req_write_i && key_ok && writable;

    clkmgr_strobe_map #(
        .NUM_PLL      (NUM_PLL),
        .CHAN_PER_PLL (CHAN_PER_PLL),
        .NUM_DIV      (NUM_DIV),
        .IDX_W        (IDX_W)
    ) u_stb (
        .fire_i   (fire),
        .region_i (region),
        .unit_i   (unit),
        .pll_o    (pll_fire),
        .chan_o   (chan_fire),
        .div_o    (div_fire)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rdata     = '0;
        st_d.pll_stb   = pll_fire;
        st_d.chan_stb  = chan_fire;
        st_d.div_stb   = div_fire;
        if (accept) begin
            st_d.rsp_valid = 1'b1;
            if (!aligned) begin
                st_d.rsp_err = 1'b1;
            end else if (req_write_i) begin
                if (fire) begin
                    st_d.regs[slot] = req_wdata_i & ~KEY_MASK;
                end else begin
                    st_d.rsp_err = 1'b1;
                end
            end else begin
                case (region)
                    RGN_LOCK: st_d.rdata = lock_word;
                    RGN_NONE: st_d.rdata = '0;
                    default:  st_d.rdata = st_q.regs[slot];
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready_o = !st_q.rsp_valid;
    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_err_o   = st_q.rsp_err;
    assign rsp_rdata_o = st_q.rdata;
    assign ctrl_regs_o = st_q.regs;
    assign pll_upd_o   = st_q.pll_stb;
    assign chan_upd_o  = st_q.chan_stb;
    assign div_upd_o   = st_q.div_stb;

endmodule

// File: rtl/clkmgr_regbank_chk.sv
module clkmgr_regbank_chk #(
    parameter int ADDR_W       = 8,
    parameter int NUM_PLL      = 4,
    parameter int CHAN_PER_PLL = 2,
    parameter int NUM_DIV      = 4,
    localparam int NUM_CHAN    = NUM_PLL * CHAN_PER_PLL,
    localparam int NREG        = NUM_PLL + NUM_CHAN + 2 * NUM_DIV
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                req_valid_i,
    input logic                req_ready_o,
    input logic                req_write_i,
    input logic [ADDR_W-1:0]   req_addr_i,
    input logic [31:0]         req_wdata_i,
    input logic                rsp_valid_o,
    input logic                rsp_err_o,
    input logic [31:0]         rsp_rdata_o,
    input logic [NUM_PLL-1:0]  pll_pwrdn_i,
    input logic [NUM_PLL-1:0]  pll_anarst_i,
    input logic [NREG*32-1:0]  ctrl_regs_o,
    input logic [NUM_PLL-1:0]  pll_upd_o,
    input logic [NUM_CHAN-1:0] chan_upd_o,
    input logic [NUM_DIV-1:0]  div_upd_o
);

    logic take;
    assign take = req_valid_i && req_ready_o;

    p_resp_next_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> rsp_valid_o);

    p_busy_while_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> !req_ready_o);

    p_bad_key_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && req_write_i && (req_wdata_i[31:24] != 8'h5A)) |=> rsp_err_o);

    p_err_keeps_regs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_err_o |-> $stable(ctrl_regs_o));

    p_misaligned_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && (req_addr_i[1:0] != 2'b00)) |=> (rsp_err_o && rsp_rdata_o == 32'd0));

    p_lock_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take && !req_write_i && req_addr_i == '0) |=>
        (rsp_rdata_o == {{(32-NUM_PLL){1'b0}}, ~($past(pll_pwrdn_i) | $past(pll_anarst_i))}));

    p_strobe_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|{pll_upd_o, chan_upd_o, div_upd_o}) |-> (rsp_valid_o && !rsp_err_o));

    p_div_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(div_upd_o));

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_own
        p_pll_hits_chans_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            pll_upd_o[p] |-> (&chan_upd_o[p*CHAN_PER_PLL +: CHAN_PER_PLL]));
    end

    for (genvar r = 0; r < NREG; r++) begin : g_key
        p_key_cleared_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ctrl_regs_o[r*32+24 +: 8] == 8'h00);
    end

endmodule

bind clkmgr_regbank clkmgr_regbank_chk #(
    .ADDR_W       (ADDR_W),
    .NUM_PLL      (NUM_PLL),
    .CHAN_PER_PLL (CHAN_PER_PLL),
    .NUM_DIV      (NUM_DIV)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_err_o    (rsp_err_o),
    .rsp_rdata_o  (rsp_rdata_o),
    .pll_pwrdn_i  (pll_pwrdn_i),
    .pll_anarst_i (pll_anarst_i),
    .ctrl_regs_o  (ctrl_regs_o),
    .pll_upd_o    (pll_upd_o),
    .chan_upd_o   (chan_upd_o),
    .div_upd_o    (div_upd_o)
);

// File: tb/clkmgr_regbank_bench.sv
module clkmgr_regbank_bench;

    localparam int ADDR_W = 8;
    localparam int NP     = 4;
    localparam int CPP    = 2;
    localparam int ND     = 4;
    localparam int NC     = NP * CPP;
    localparam int NREG   = NP + NC + 2 * ND;
    localparam int NWORDS = 1 << (ADDR_W - 2);

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              req_valid_i = 1'b0;
    logic              req_ready_o;
    logic              req_write_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [31:0]       req_wdata_i = '0;
    logic              rsp_valid_o;
    logic              rsp_err_o;
    logic [31:0]       rsp_rdata_o;
    logic [NP-1:0]     pll_pwrdn_i = '1;
    logic [NP-1:0]     pll_anarst_i = '0;
    logic [NREG*32-1:0] ctrl_regs_o;
    logic [NP-1:0]     pll_upd_o;
    logic [NC-1:0]     chan_upd_o;
    logic [ND-1:0]     div_upd_o;

    always #10 clk_i = ~clk_i;

    clkmgr_regbank #(
        .ADDR_W       (ADDR_W),
        .NUM_PLL      (NP),
        .CHAN_PER_PLL (CPP),
        .NUM_DIV      (ND)
    ) u_clkmgr_regbank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_valid_i  (req_valid_i),
        .req_ready_o  (req_ready_o),
        .req_write_i  (req_write_i),
        .req_addr_i   (req_addr_i),
        .req_wdata_i  (req_wdata_i),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_err_o    (rsp_err_o),
        .rsp_rdata_o  (rsp_rdata_o),
        .pll_pwrdn_i  (pll_pwrdn_i),
        .pll_anarst_i (pll_anarst_i),
        .ctrl_regs_o  (ctrl_regs_o),
        .pll_upd_o    (pll_upd_o),
        .chan_upd_o   (chan_upd_o),
        .div_upd_o    (div_upd_o)
    );

    int checks = 0;
    int failures = 0;
    logic [31:0] model [NREG];

    logic        g_valid, g_err;
    logic [31:0] g_rdata;
    logic [NP-1:0] g_pll;
    logic [NC-1:0] g_chan;
    logic [ND-1:0] g_div;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [ADDR_W-1:0] addr, input logic [31:0] data);
        @(negedge clk_i);
        check("R10 ready before request", 64'(req_ready_o), 64'd1);
        req_valid_i = 1'b1;
        req_write_i = wr;
        req_addr_i  = addr;
        req_wdata_i = data;
        @(negedge clk_i);
        req_valid_i = 1'b0;
        g_valid = rsp_valid_o;
        g_err   = rsp_err_o;
        g_rdata = rsp_rdata_o;
        g_pll   = pll_upd_o;
        g_chan  = chan_upd_o;
        g_div   = div_upd_o;
        check("R10 response valid", 64'(g_valid), 64'd1);
        check("R10 ready low during response", 64'(req_ready_o), 64'd0);
    endtask

    function automatic logic [63:0] exp_strobes(input int w);
        logic [NP-1:0] p;
        logic [NC-1:0] c;
        logic [ND-1:0] d;
        p = '0; c = '0; d = '0;
        if (w >= 1 && w <= NP) begin
            p[w-1] = 1'b1;
            for (int i = 0; i < CPP; i++) c[(w-1)*CPP + i] = 1'b1;
        end else if (w > NP && w <= NP + NC) begin
            c[w-1-NP] = 1'b1;
        end else if (w > NP + NC && w <= NREG) begin
            d[(w-1-NP-NC)/2] = 1'b1;
        end
        return 64'({p, c, d});
    endfunction

    function automatic logic [31:0] pattern(input int w, input int pass);
        logic [23:0] v;
        v = 24'(w * 32'h0001_0203) ^ 24'h00A5C3;
        if (pass != 0) v = ~v;
        return {8'h5A, v};
    endfunction

    task automatic read_expect(input int w, input string tag);
        access(1'b0, ADDR_W'(w * 4), 32'd0);
        check({tag, " read error flag"}, 64'(g_err), 64'd0);
        if (w >= 1 && w <= NREG) check({tag, " read data"}, 64'(g_rdata), 64'(model[w-1]));
        else if (w > NREG)       check({tag, " unmapped read data"}, 64'(g_rdata), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 32'd0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1: idle state after reset
        check("R1 ready after reset", 64'(req_ready_o), 64'd1);
        check("R1 no response after reset", 64'(rsp_valid_o), 64'd0);
        check("R1 strobes idle", 64'({pll_upd_o, chan_upd_o, div_upd_o}), 64'd0);
        check("R1 config bus zero", 64'(|ctrl_regs_o), 64'd0);
        for (int w = 1; w < NWORDS; w++) read_expect(w, "R1 R9 sweep");

        // R3 R6 R7 R8: two patterns on each mapped word
        for (int pass = 0; pass < 2; pass++) begin
            for (int w = 1; w <= NREG; w++) begin
                logic [31:0] d;
                d = pattern(w, pass);
                access(1'b1, ADDR_W'(w * 4), d);
                check("R2 keyed write accepted", 64'(g_err), 64'd0);
                check("R6 R7 R8 strobe set", 64'({g_pll, g_chan, g_div}), exp_strobes(w));
                @(negedge clk_i);
                check("R6 strobe lasts one cycle", 64'({pll_upd_o, chan_upd_o, div_upd_o}), 64'd0);
                model[w-1] = d & 32'h00FF_FFFF;
                read_expect(w, "R3 stored value");
            end
        end

        // R2: wrong keys
        for (int w = 1; w <= NREG; w++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0] key;
                case (k)
                    0: key = 8'h00; 1: key = 8'hA5; 2: key = 8'h5B;
                    3: key = 8'hDA; 4: key = 8'hFF; default: key = 8'h59;
                endcase
                access(1'b1, ADDR_W'(w * 4), {key, 24'h123456});
                check("R2 bad key error", 64'(g_err), 64'd1);
                check("R2 bad key no strobe", 64'({g_pll, g_chan, g_div}), 64'd0);
            end
            read_expect(w, "R2 unchanged");
        end

        // R4: misaligned
        for (int w = 1; w <= NREG; w++) begin
            for (int off = 1; off < 4; off++) begin
                access(1'b1, ADDR_W'(w * 4 + off), 32'h5A00_0BAD);
                check("R4 misaligned write error", 64'(g_err), 64'd1);
                check("R4 misaligned no strobe", 64'({g_pll, g_chan, g_div}), 64'd0);
                access(1'b0, ADDR_W'(w * 4 + off), 32'd0);
                check("R4 misaligned read error", 64'(g_err), 64'd1);
                check("R4 misaligned read data", 64'(g_rdata), 64'd0);
            end
            read_expect(w, "R4 unchanged");
        end

        // R5 R9: writes to lock word and unmapped words
        for (int w = 0; w < NWORDS; w++) begin
            if (w == 0 || w > NREG) begin
                access(1'b1, ADDR_W'(w * 4), 32'h5AFF_FFFF);
                check("R5 R9 unwritable error", 64'(g_err), 64'd1);
                check("R5 R9 unwritable no strobe", 64'({g_pll, g_chan, g_div}), 64'd0);
            end
        end
        for (int w = 1; w < NWORDS; w++) read_expect(w, "R9 after rejected writes");

        // R5: lock word over all input combinations
        for (int v = 0; v < (1 << (2 * NP)); v++) begin
            logic [NP-1:0] nl;
            @(negedge clk_i);
            pll_pwrdn_i  = NP'(v);
            pll_anarst_i = NP'(v >> NP);
            nl = ~(pll_pwrdn_i | pll_anarst_i);
            access(1'b0, '0, 32'd0);
            check("R5 lock error flag", 64'(g_err), 64'd0);
            check("R5 lock word", 64'(g_rdata), 64'({{(32-NP){1'b0}}, nl}));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule